// File: doc/BRIEF.md
# Power Sequence Control Register Block

This block is a small set of control registers on a simple register bus: an address, a write strobe with write data, and a read strobe with combinational read data. It controls an external power sequencer. Three single-bit controls make up the shutdown sequence: a soft-reset release, a main clock enable and a power-off request. A fourth register drives two general-purpose output pins through a masked write.

Software shuts the system down in three steps, in order. It releases the soft reset, then enables the main clock, then writes the power-off request. The block raises its power-off line only if the request arrives after the first two steps are already in place, and it then holds the line until the system reset. The pin register is write-only. Each of its two data bits is updated only when its own enable bit in the upper half-word is set in the same write.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both pins, the power-off line and every readable register are 0.
- R2: A write to offset 0x80 with bit 16 set loads bit 0 of the write data into pin 0. Pin 0 changes on the clock edge that accepts the write.
- R3: A write to offset 0x80 with bit 17 set loads bit 1 into pin 1. A pin whose enable bit (16 for pin 0, 17 for pin 1) is clear keeps its level.
- R4: A read of offset 0x80 returns 0 whatever the pin levels are.
- R5: Bit 0 written at offset 0x00 is the reset-release control. It reads back at bit 0 of that offset, and the other bits read as 0.
- R6: Bit 0 written at offset 0x04 is the main clock enable. It reads back at bit 0 of that offset, and the other bits read as 0.
- R7: A write of 1 to bit 0 at offset 0x50 raises the power-off line on that edge when reset-release and clock-enable are both already 1.
- R8: A power-off write made while reset-release or clock-enable is still 0 is ignored. The line stays 0 and no request is remembered.
- R9: Once raised, the power-off line stays 1 until reset, whatever is written afterwards.
- R10: Writes to any other offset change nothing, and reads of any other offset return 0.
- R11: A read of offset 0x50 returns the power-off line state at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the strobe |
| pin_out | output | 2 | General-purpose output pin levels |
| pwroff_req | output | 1 | Power-off request to the external sequencer |

## Verification
Every register and output updates on the rising edge that accepts the write. The bench therefore drives each write on a falling edge, releases it on the next falling edge, and samples the pins and the power-off line at that same falling edge. This is exactly one edge after the stimulus. Read data is combinational, so it is due in the cycle of the read strobe; the bench samples it one nanosecond after driving the strobe and before any further edge. When a write is meant to have no effect, the pins, the power-off line or a follow-up read are checked after the edge that would have applied it.

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int OFF_RST  = 'h00,
  parameter int OFF_CLK  = 'h04,
  parameter int OFF_PWR  = 'h50,
  parameter int OFF_PIN  = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        pin_out,
  output logic              pwroff_req
);

  localparam int MASK_LSB = DATA_W / 2;

  logic rst_rel, clk_en;

  wire hit_rst = (bus_addr == ADDR_W'(OFF_RST));
  wire hit_clk = (bus_addr == ADDR_W'(OFF_CLK));
  wire hit_pwr = (bus_addr == ADDR_W'(OFF_PWR));
  wire hit_pin = (bus_addr == ADDR_W'(OFF_PIN));

  wire armed = rst_rel && clk_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_rel    <= 1'b0;
      clk_en     <= 1'b0;
      pwroff_req <= 1'b0;
      pin_out    <= 2'b00;
    end else if (bus_wr) begin
      if (hit_rst) rst_rel <= bus_wdata[0];
      if (hit_clk) clk_en  <= bus_wdata[0];
      if (hit_pwr && bus_wdata[0] && armed) pwroff_req <= 1'b1;
      if (hit_pin) begin
        for (int i = 0; i < 2; i++)
          if (bus_wdata[MASK_LSB+i]) pin_out[i] <= bus_wdata[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_rst)      bus_rdata[0] = rst_rel;
      else if (hit_clk) bus_rdata[0] = clk_en;
      else if (hit_pwr) bus_rdata[0] = pwroff_req;
    end
  end

  assert_pwroff_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_req |=> pwroff_req);

  assert_pwroff_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwroff_req) |-> $past(rst_rel && clk_en && bus_wr && hit_pwr));

  assert_pin_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_pin) |=> $stable(pin_out));

  assert_pin_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_pin) |-> bus_rdata == '0);

  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit_rst && !hit_clk && !hit_pwr) |-> bus_rdata == '0);

endmodule

// File: tb/pwrseq_ctrl_bench.sv
module pwrseq_ctrl_bench;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_rdata;
  logic [1:0]  pin_out;
  logic        pwroff_req;
  int vecs = 0, errs = 0;

  pwrseq_ctrl u_pwrseq_ctrl (.clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr,
    .bus_rd, .bus_rdata, .pin_out, .pwroff_req);

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pins", 32'(pin_out), 0);
    check("R1 pwroff", 32'(pwroff_req), 0);
    rd(8'h00, d); check("R1 rst reg", d, 0);
    rd(8'h04, d); check("R1 clk reg", d, 0);
    rd(8'h50, d); check("R1 pwr reg", d, 0);
  endtask

  task automatic t_pins();
    logic [31:0] d;
    wr(8'h80, 32'h0001_0003); check("R2 pin0 set only", 32'(pin_out), 1);
    wr(8'h80, 32'h0002_0002); check("R3 pin1 set only", 32'(pin_out), 3);
    wr(8'h80, 32'h0000_0000); check("R3 no mask keeps", 32'(pin_out), 3);
    wr(8'h80, 32'h0001_0000); check("R2 pin0 clear", 32'(pin_out), 2);
    rd(8'h80, d); check("R4 pin read zero", d, 0);
    wr(8'h80, 32'h0003_0001); check("R3 both masked", 32'(pin_out), 1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R5 rst readback", d, 1);
    wr(8'h00, 32'h0000_0000); rd(8'h00, d); check("R5 rst clear", d, 0);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R6 clk readback", d, 1);
    wr(8'h04, 32'h0000_0000); rd(8'h04, d); check("R6 clk clear", d, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(8'h50, 1); check("R8 no steps", 32'(pwroff_req), 0);
    wr(8'h00, 1);
    wr(8'h50, 1); check("R8 only rst", 32'(pwroff_req), 0);
    wr(8'h00, 0); wr(8'h04, 1);
    wr(8'h50, 1); check("R8 only clk", 32'(pwroff_req), 0);
    wr(8'h00, 1); check("R8 nothing remembered", 32'(pwroff_req), 0);
    wr(8'h50, 0); check("R7 zero write", 32'(pwroff_req), 0);
    wr(8'h50, 1); check("R7 ordered request", 32'(pwroff_req), 1);
    rd(8'h50, d); check("R11 pwr readback", d, 1);
    wr(8'h50, 0); wr(8'h00, 0); wr(8'h04, 0);
    check("R9 sticky", 32'(pwroff_req), 1);
    do_reset(); check("R9 cleared by reset", 32'(pwroff_req), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h80, 32'h0003_0002);
    wr(8'h84, 32'h0003_0001); check("R10 pins untouched", 32'(pin_out), 2);
    wr(8'h01, 1); rd(8'h00, d); check("R10 rst untouched", d, 0);
    wr(8'h54, 1); rd(8'h50, d); check("R10 pwr untouched", d, 0);
    rd(8'h84, d); check("R10 read zero", d, 0);
    rd(8'hFF, d); check("R10 read zero high", d, 0);
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset(); t_pins(); t_regs(); t_order(); t_unmapped();
        do_reset(); t_reset();
      end
      begin
        repeat (5000) @(posedge clk);
        errs++; vecs++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule